// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Generator

This block is the timing engine of a master on a single-wire, open-drain bus. Software asks for one of three bus operations by writing a control word with start bits: a bus reset with presence detection, a write-0 slot, or a combined write-1/read slot. The block times the slot in microseconds and drives the line low only in the phases the slot calls for. The start bit it accepted stays visible until the slot is over, and the hardware then clears it.

A presence flag records whether any slave pulled the line low after the reset pulse. A read-data flag records the level seen during the last write-1/read slot. A slave that wants to return a 0 holds the line low after the master lets go. A line that floats back high is read as 1.

The microsecond base comes from a clock divider whose ratio is a parameter. The block never drives the line high. It only asserts a pull-down enable, and the sampled line level comes back on a separate input through a two-stage synchronizer. The control and status pins are plain level signals with no handshake.

Top module: `owm_master`

## Requirements
- R1: After reset, `ctrl_bits`, `busy`, `presence`, `rd_bit` and `bus_drive_low` are all 0.
- R2: When idle, a write (`cmd_we`=1) with at least one start bit set loads exactly one bit into `ctrl_bits` on that clock edge. The bits are bit0 = bus reset, bit1 = write-0, bit2 = write-1/read. The priority is bit0 over bit1 over bit2, and `busy` is high while any bit is set. A write with all bits 0 does nothing.
- R3: A write-0 slot pulls the line low for 100 us, lasts 117 us in total, and then clears bit1.
- R4: A write-1/read slot pulls the line low for 5 us, lasts 117 us in total, and then clears bit2.
- R5: At the end of a write-1/read slot, `rd_bit` takes the synchronized line level sampled 15 us after the slot began. It changes at no other time.
- R6: A reset sequence pulls the line low for 480 us and releases it. It samples the line 550 us after the start and ends at 960 us. At the end it sets `presence` to 1 if the sample was low and to 0 otherwise, and clears bit0. `presence` changes at no other time.
- R7: Writes that arrive while `busy` is high are ignored: `ctrl_bits` and the slot timing are unchanged.
- R8: `bus_drive_low` is asserted only while a slot is in progress. There is no output that drives the line high.
- R9: One microsecond is `CLK_PER_US` clock cycles, counted from the edge that accepts the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Control write strobe |
| cmd_bits | input | 3 | Start bits: bit0 bus reset, bit1 write-0, bit2 write-1/read |
| ctrl_bits | output | 3 | Accepted start bit, cleared by hardware at slot end |
| busy | output | 1 | A slot is in progress |
| presence | output | 1 | A slave answered the last reset |
| rd_bit | output | 1 | Level read in the last write-1/read slot |
| bus_drive_low | output | 1 | Pull-down enable for the open-drain line |
| bus_in | input | 1 | Sampled level of the bus line (asynchronous) |

## Verification
The bench targets start-bit priority when several bits arrive together, and writes that land in the middle of a slot. A wrong priority encoder would launch the wrong slot. A design that does not gate writes while busy would restart or change the slot part-way through. It measures the low phase and the full slot length in clock cycles for every slot type. An off-by-one in the prescaler or the microsecond compare would show up as a width error of one microsecond or one clock. Read-0, read-1, presence and no-presence cases are all run. A design that sampled outside the slave's pull-down window, or inverted the presence sense, would latch the wrong flag value.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    SK_NONE  = 2'd0,
    SK_RESET = 2'd1,
    SK_WR0   = 2'd2,
    SK_WR1RD = 2'd3
  } slot_kind_e;

  localparam int unsigned NUM_START = 3;
  localparam int unsigned BIT_RESET = 0;
  localparam int unsigned BIT_WR0   = 1;
  localparam int unsigned BIT_WR1RD = 2;
endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pre_q <= '0;
    end else if (pre_q == LAST) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign tick = (pre_q == LAST) && !clear;
endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sr_q[i] <= 1'b1;
          else        sr_q[i] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) sr_q[i] <= 1'b1;
          else        sr_q[i] <= sr_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/owm_slot_timer.sv
module owm_slot_timer #(
  parameter int unsigned US_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            tick,
  input  logic [US_W-1:0] low_us,
  input  logic [US_W-1:0] sample_us,
  input  logic [US_W-1:0] total_us,
  output logic            low_phase,
  output logic            sample_now,
  output logic            done
);
  logic [US_W-1:0] us_q;

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      us_q <= '0;
    end else if (tick) begin
      us_q <= us_q + 1'b1;
    end
  end

  assign low_phase  = us_q < low_us;
  assign sample_now = tick && (us_q == sample_us - 1'b1);
  assign done       = tick && (us_q == total_us - 1'b1);
endmodule

// File: rtl/owm_master.sv
module owm_master #(
  parameter int unsigned CLK_PER_US    = 100,
  parameter int unsigned US_W          = 10,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned RST_LOW_US    = 480,
  parameter int unsigned RST_SAMPLE_US = 550,
  parameter int unsigned RST_TOTAL_US  = 960,
  parameter int unsigned W0_LOW_US     = 100,
  parameter int unsigned W0_TOTAL_US   = 117,
  parameter int unsigned W1_LOW_US     = 5,
  parameter int unsigned W1_SAMPLE_US  = 15,
  parameter int unsigned W1_TOTAL_US   = 117
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [2:0] cmd_bits,
  output logic [2:0] ctrl_bits,
  output logic       busy,
  output logic       presence,
  output logic       rd_bit,
  output logic       bus_drive_low,
  input  logic       bus_in
);
  import owm_pkg::*;

  logic [NUM_START-1:0] ctrl_q;
  logic [NUM_START-1:0] pick;
  logic                 accept;
  logic                 tick;
  logic                 line_s;
  logic                 low_phase, sample_now, done;
  logic                 samp_q, pres_q, rd_q;
  logic [US_W-1:0]      low_us, smp_us, tot_us;
  slot_kind_e           kind;

  assign busy   = |ctrl_q;
  assign accept = cmd_we && !busy && (|cmd_bits);

  // fixed priority: reset, then write-0, then write-1/read
  always_comb begin
    pick = '0;
    if (cmd_bits[BIT_RESET])    pick[BIT_RESET] = 1'b1;
    else if (cmd_bits[BIT_WR0]) pick[BIT_WR0]   = 1'b1;
    else                        pick[BIT_WR1RD] = 1'b1;
  end

  always_comb begin
    if (ctrl_q[BIT_RESET])      kind = SK_RESET;
    else if (ctrl_q[BIT_WR0])   kind = SK_WR0;
    else if (ctrl_q[BIT_WR1RD]) kind = SK_WR1RD;
    else                        kind = SK_NONE;
  end

  always_comb begin
    unique case (kind)
      SK_RESET: begin
        low_us = US_W'(RST_LOW_US);
        smp_us = US_W'(RST_SAMPLE_US);
        tot_us = US_W'(RST_TOTAL_US);
      end
      SK_WR0: begin
        low_us = US_W'(W0_LOW_US);
        smp_us = US_W'(W0_TOTAL_US);
        tot_us = US_W'(W0_TOTAL_US);
      end
      default: begin
        low_us = US_W'(W1_LOW_US);
        smp_us = US_W'(W1_SAMPLE_US);
        tot_us = US_W'(W1_TOTAL_US);
      end
    endcase
  end

  owm_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!busy),
    .tick  (tick)
  );

  owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (bus_in),
    .dout  (line_s)
  );

  owm_slot_timer #(.US_W(US_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .tick       (tick),
    .low_us     (low_us),
    .sample_us  (smp_us),
    .total_us   (tot_us),
    .low_phase  (low_phase),
    .sample_now (sample_now),
    .done       (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      samp_q <= 1'b1;
      pres_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      if (accept) begin
        ctrl_q <= pick;
      end else if (busy && done) begin
        ctrl_q <= '0;
        if (kind == SK_RESET) pres_q <= ~samp_q;
        if (kind == SK_WR1RD) rd_q   <= samp_q;
      end
      if (busy && sample_now) samp_q <= line_s;
    end
  end

  assign ctrl_bits     = ctrl_q;
  assign presence      = pres_q;
  assign rd_bit        = rd_q;
  assign bus_drive_low = busy && low_phase;
endmodule

// File: rtl/owm_master_chk.sv
module owm_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_we,
  input logic [2:0] cmd_bits,
  input logic [2:0] ctrl_bits,
  input logic       busy,
  input logic       presence,
  input logic       rd_bit,
  input logic       bus_drive_low
);
  assert_onehot_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_bits));

  assert_busy_matches_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (ctrl_bits != 3'b000));

  assert_zero_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_we && cmd_bits == 3'b000) |=> !busy);

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (ctrl_bits == $past(ctrl_bits) || ctrl_bits == 3'b000));

  assert_drive_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_low |-> busy);

  assert_presence_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(presence));

  assert_rdbit_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rd_bit));
endmodule

bind owm_master owm_master_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_we        (cmd_we),
  .cmd_bits      (cmd_bits),
  .ctrl_bits     (ctrl_bits),
  .busy          (busy),
  .presence      (presence),
  .rd_bit        (rd_bit),
  .bus_drive_low (bus_drive_low)
);

// File: tb/owm_master_bench.sv
module owm_master_bench;
  localparam int CPU = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [2:0] cmd_bits = 3'b000;
  logic [2:0] ctrl_bits;
  logic       busy, presence, rd_bit, bus_drive_low;
  logic       bus_in;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // slave behaviour
  logic slave_present = 1'b0;
  logic slave_bit = 1'b1;
  logic slave_pull;

  // reference model state
  int   m_kind = 0;   // 0 idle, 1 reset, 2 write-0, 3 write-1/read
  int   m_cyc = 0;
  logic m_pres = 1'b0;
  logic m_rd = 1'b0;

  always #2 clk = ~clk;

  owm_master #(.CLK_PER_US(CPU)) u_owm_master (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_we        (cmd_we),
    .cmd_bits      (cmd_bits),
    .ctrl_bits     (ctrl_bits),
    .busy          (busy),
    .presence      (presence),
    .rd_bit        (rd_bit),
    .bus_drive_low (bus_drive_low),
    .bus_in        (bus_in)
  );

  function automatic int low_of(int k);
    case (k)
      1: return 480 * CPU;
      2: return 100 * CPU;
      3: return 5 * CPU;
      default: return 0;
    endcase
  endfunction

  function automatic int total_of(int k);
    case (k)
      1: return 960 * CPU;
      2, 3: return 117 * CPU;
      default: return 0;
    endcase
  endfunction

  always_comb begin
    slave_pull = 1'b0;
    if (m_kind == 3 && !slave_bit && m_cyc < 30 * CPU) slave_pull = 1'b1;
    if (m_kind == 1 && slave_present && m_cyc >= 495 * CPU && m_cyc < 600 * CPU) slave_pull = 1'b1;
  end
  assign bus_in = !(bus_drive_low || slave_pull);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_kind <= 0;
      m_cyc  <= 0;
      m_pres <= 1'b0;
      m_rd   <= 1'b0;
    end else if (m_kind == 0) begin
      if (cmd_we && cmd_bits != 3'b000) begin
        m_kind <= cmd_bits[0] ? 1 : (cmd_bits[1] ? 2 : 3);
        m_cyc  <= 0;
      end
    end else if (m_cyc + 1 == total_of(m_kind)) begin
      if (m_kind == 1) m_pres <= slave_present;
      if (m_kind == 3) m_rd   <= slave_bit;
      m_kind <= 0;
    end else begin
      m_cyc <= m_cyc + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 ctrl_bits", ctrl_bits, (m_kind == 0) ? 0 : (1 << (m_kind - 1)));
      check("R2 busy", busy, m_kind != 0);
      check("R8 drive_low", bus_drive_low, (m_kind != 0) && (m_cyc < low_of(m_kind)));
      check("R6 presence", presence, m_pres);
      check("R5 rd_bit", rd_bit, m_rd);
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // start a slot; measure its low phase and length; optionally poke mid-slot
  task automatic run_slot(input logic [2:0] bits, input int poke_at,
                          output int low_n, output int busy_n, output logic [2:0] seen);
    cmd_we = 1'b1; cmd_bits = bits;
    @(negedge clk);
    cmd_we = 1'b0; cmd_bits = 3'b000;
    seen = ctrl_bits;
    low_n = 0; busy_n = 0;
    while (busy) begin
      if (bus_drive_low) low_n++;
      busy_n++;
      if (busy_n == poke_at) begin cmd_we = 1'b1; cmd_bits = 3'b111; end
      else begin cmd_we = 1'b0; cmd_bits = 3'b000; end
      @(negedge clk);
    end
    cmd_we = 1'b0; cmd_bits = 3'b000;
    @(negedge clk);
  endtask

  initial begin
    int lo, bz;
    logic [2:0] sn;
    repeat (4) @(negedge clk);
    check("R1 ctrl_bits", ctrl_bits, 0);
    check("R1 busy", busy, 0);
    check("R1 presence", presence, 0);
    check("R1 rd_bit", rd_bit, 0);
    check("R1 drive", bus_drive_low, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // all-zero write does nothing
    cmd_we = 1'b1; cmd_bits = 3'b000;
    @(negedge clk);
    cmd_we = 1'b0;
    check("R2 zero write", busy, 0);

    run_slot(3'b010, 0, lo, bz, sn);
    check("R2 wr0 bit", sn, 3'b010);
    check("R3 low", lo, 100 * CPU);
    check("R3 total", bz, 117 * CPU);
    check("R9 wr0 total", bz, 117 * CPU);

    slave_bit = 1'b1;
    run_slot(3'b100, 0, lo, bz, sn);
    check("R4 low", lo, 5 * CPU);
    check("R4 total", bz, 117 * CPU);
    check("R5 read one", rd_bit, 1);

    slave_bit = 1'b0;
    run_slot(3'b100, 0, lo, bz, sn);
    check("R5 read zero", rd_bit, 0);
    check("R8 released after", bus_drive_low, 0);

    slave_present = 1'b1;
    run_slot(3'b111, 0, lo, bz, sn);
    check("R2 priority reset", sn, 3'b001);
    check("R6 low", lo, 480 * CPU);
    check("R6 total", bz, 960 * CPU);
    check("R6 present", presence, 1);

    slave_present = 1'b0;
    run_slot(3'b001, 0, lo, bz, sn);
    check("R6 absent", presence, 0);

    slave_bit = 1'b1;
    run_slot(3'b110, 0, lo, bz, sn);
    check("R2 priority wr0", sn, 3'b010);

    run_slot(3'b100, 3, lo, bz, sn);
    check("R7 ignored kind", sn, 3'b100);
    check("R7 ignored total", bz, 117 * CPU);
    check("R7 ignored low", lo, 5 * CPU);
    check("R5 after poke", rd_bit, 1);

    run_slot(3'b010, 200, lo, bz, sn);
    check("R7 wr0 poke total", bz, 117 * CPU);
    check("R7 wr0 poke low", lo, 100 * CPU);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule